// File: doc/BRIEF.md
# Stride Stream Prefetcher

This block sits beside a data cache and watches the demand accesses it serves. Each demand access makes it propose the cache block that follows the one just touched. It also tracks the block-granular distance between successive accesses. When the same nonzero distance shows up twice in a row, the access stream is treated as strided. The block then also proposes the blocks one, two and three strides beyond the current one. Strides may be positive or negative.

Every proposal must stay inside the 4 KB page of the access that produced it, and any that would leave it is discarded. The proposals that survive are loaded into a small queue and offered one per cycle on a valid/ready request port, as 64-byte aligned byte addresses. A new demand access throws away whatever the previous access left unissued.

Top module: `stride_prefetcher`

## Requirements
- R1: After a demand access in cycle t, the first request offered from cycle t+1 is the following block, demand block address plus 64 bytes, as long as that block lies in the same 4 KB page.
- R2: No request is ever offered whose address bits above bit 11 differ from those of the demand access that produced it. Such candidates are dropped, including the following block when the access hits the last block of a page.
- R3: A stride is confirmed only when the current block difference is nonzero and equals the difference between the two accesses before it, so the third access of a constant-stride run is the first one to produce stride requests.
- R4: On a confirmed stride S, after the following-block request the block offers current block plus S, plus 2S and plus 3S, in that order, keeping only those in the page.
- R5: A difference that does not match the previous one produces only the following-block request, and it becomes the new candidate stride.
- R6: Differences are taken in two's complement, so a descending run with a constant step is confirmed like an ascending one.
- R7: A request that is offered and not accepted holds the same address until it is accepted. One request is accepted for each cycle in which pf_vld and pf_rdy are both high.
- R8: A demand access discards all requests not yet accepted. From the next cycle only requests for the new access are offered.
- R9: While reset is asserted and right after it, no request is offered. The first access after reset can only produce a following-block request.
- R10: Repeated accesses to the same block never confirm a stride.
- R11: Every request address has its low 6 bits at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dmd_vld | input | 1 | A demand access occurs this cycle |
| dmd_addr | input | 32 | Byte address of the demand access |
| pf_vld | output | 1 | A prefetch request is offered |
| pf_rdy | input | 1 | The consumer accepts the offered request |
| pf_addr | output | 32 | 64-byte aligned byte address of the request |

## Verification
The bench targets the page edge. An access to a page's last block must offer nothing. A stride landing one step past the page end must keep only the requests below that end. A design that compared full addresses instead of page numbers would leak requests into the next page. Negative and zero differences are driven directly: a design using unsigned differences would miss descending runs, and a design that did not exclude zero would flood requests on a repeated block. A demand access arriving while a burst is half drained, and a stalled consumer, expose a queue that does not flush or that moves its head without a handshake.

// File: rtl/pf_pkg.sv
package pf_pkg;
  localparam int unsigned PF_ADDR_W    = 32;
  localparam int unsigned PF_BLK_LG    = 6;
  localparam int unsigned PF_PAGE_LG   = 12;
  localparam int unsigned PF_LOOKAHEAD = 3;
endpackage

// File: rtl/pf_stride_detect.sv
module pf_stride_detect #(
  parameter int unsigned BAW = 26
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           acc_vld,
  input  logic [BAW-1:0] acc_blk,
  output logic           stream_hit,
  output logic [BAW-1:0] stride
);
  logic [BAW-1:0] prev_q, prev_d;
  logic [BAW-1:0] strd_q, strd_d;
  logic           seen_q, seen_d;
  logic [BAW-1:0] diff;

  always_comb begin
    diff       = acc_blk - prev_q;
    stream_hit = seen_q && (diff == strd_q) && (|diff);
    prev_d     = prev_q;
    strd_d     = strd_q;
    seen_d     = seen_q;
    if (acc_vld) begin
      prev_d = acc_blk;
      seen_d = 1'b1;
      if (seen_q) strd_d = diff;
    end
  end

  assign stride = strd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      strd_q <= '0;
      seen_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      strd_q <= strd_d;
      seen_q <= seen_d;
    end
  end
endmodule

// File: rtl/pf_cand_gen.sv
module pf_cand_gen #(
  parameter int unsigned BAW  = 26,
  parameter int unsigned PGB  = 6,
  parameter int unsigned NC   = 4,
  parameter int unsigned CW   = 3
) (
  input  logic [BAW-1:0]         blk,
  input  logic                   stream_hit,
  input  logic [BAW-1:0]         stride,
  output logic [NC-1:0][BAW-1:0] cand,
  output logic [CW-1:0]          cand_cnt
);
  logic [NC-1:0][BAW-1:0] raw;
  logic [NC-1:0]          keep;

  for (genvar k = 0; k < NC; k++) begin : g_cand
    if (k == 0) begin : g_next
      assign raw[k] = blk + BAW'(1);
      assign keep[k] = (raw[k][BAW-1:PGB] == blk[BAW-1:PGB]);
    end else begin : g_strd
      assign raw[k] = blk + BAW'(k) * stride;
      assign keep[k] = stream_hit && (raw[k][BAW-1:PGB] == blk[BAW-1:PGB]);
    end
  end

  always_comb begin
    cand     = '0;
    cand_cnt = '0;
    for (int i = 0; i < NC; i++) begin
      if (keep[i]) begin
        cand[cand_cnt] = raw[i];
        cand_cnt       = cand_cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/pf_queue.sv
module pf_queue #(
  parameter int unsigned W     = 26,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CW    = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [DEPTH-1:0][W-1:0] ld_data,
  input  logic [CW-1:0]           ld_cnt,
  input  logic                    deq,
  output logic                    out_vld,
  output logic [W-1:0]            out_data
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0][W-1:0] mem_q;
  logic [CW-1:0]           cnt_q, cnt_d;
  logic [PW-1:0]           head_q, head_d;

  assign out_vld  = (cnt_q != '0);
  assign out_data = mem_q[head_q];

  always_comb begin
    cnt_d  = cnt_q;
    head_d = head_q;
    if (load) begin
      cnt_d  = ld_cnt;
      head_d = '0;
    end else if (out_vld && deq) begin
      cnt_d  = cnt_q - CW'(1);
      head_d = head_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      head_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      head_q <= head_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load) mem_q <= ld_data;
  end
endmodule

// File: rtl/stride_prefetcher.sv
module stride_prefetcher
  import pf_pkg::*;
#(
  parameter int unsigned ADDR_W    = PF_ADDR_W,
  parameter int unsigned BLK_LG    = PF_BLK_LG,
  parameter int unsigned PAGE_LG   = PF_PAGE_LG,
  parameter int unsigned LOOKAHEAD = PF_LOOKAHEAD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dmd_vld,
  input  logic [ADDR_W-1:0] dmd_addr,
  output logic              pf_vld,
  input  logic              pf_rdy,
  output logic [ADDR_W-1:0] pf_addr
);
  localparam int unsigned BAW   = ADDR_W - BLK_LG;
  localparam int unsigned PGB   = PAGE_LG - BLK_LG;
  localparam int unsigned DEPTH = LOOKAHEAD + 1;
  localparam int unsigned CW    = $clog2(DEPTH + 1);

  logic [BAW-1:0]           blk;
  logic                     hit;
  logic [BAW-1:0]           stride;
  logic [DEPTH-1:0][BAW-1:0] cand;
  logic [CW-1:0]            cand_cnt;
  logic [BAW-1:0]           head_blk;

  assign blk = dmd_addr[ADDR_W-1:BLK_LG];

  pf_stride_detect #(.BAW(BAW)) u_det (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_vld    (dmd_vld),
    .acc_blk    (blk),
    .stream_hit (hit),
    .stride     (stride)
  );

  pf_cand_gen #(.BAW(BAW), .PGB(PGB), .NC(DEPTH), .CW(CW)) u_gen (
    .blk        (blk),
    .stream_hit (hit),
    .stride     (stride),
    .cand       (cand),
    .cand_cnt   (cand_cnt)
  );

  pf_queue #(.W(BAW), .DEPTH(DEPTH), .CW(CW)) u_q (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (dmd_vld),
    .ld_data  (cand),
    .ld_cnt   (cand_cnt),
    .deq      (pf_rdy),
    .out_vld  (pf_vld),
    .out_data (head_blk)
  );

  assign pf_addr = {head_blk, {BLK_LG{1'b0}}};
endmodule

// File: rtl/stride_prefetcher_chk.sv
module stride_prefetcher_chk #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned BLK_LG    = 6,
  parameter int unsigned PAGE_LG   = 12,
  parameter int unsigned LOOKAHEAD = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dmd_vld,
  input logic [ADDR_W-1:0] dmd_addr,
  input logic              pf_vld,
  input logic              pf_rdy,
  input logic [ADDR_W-1:0] pf_addr
);
  localparam int unsigned PW = ADDR_W - PAGE_LG;

  logic [PW-1:0] page_q;
  logic [3:0]    taken_q;
  logic          last_blk;

  assign last_blk = &dmd_addr[PAGE_LG-1:BLK_LG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q  <= '0;
      taken_q <= '0;
    end else begin
      if (dmd_vld) page_q <= dmd_addr[ADDR_W-1:PAGE_LG];
      if (dmd_vld) taken_q <= '0;
      else if (pf_vld && pf_rdy) taken_q <= taken_q + 4'd1;
    end
  end

  AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    pf_vld |-> (pf_addr[BLK_LG-1:0] == '0)); // R11

  AST_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    pf_vld |-> (pf_addr[ADDR_W-1:PAGE_LG] == page_q)); // R2

  AST_NEXT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (dmd_vld && !last_blk) |=> (pf_vld &&
      pf_addr == ({$past(dmd_addr[ADDR_W-1:BLK_LG]), {BLK_LG{1'b0}}} + ADDR_W'(1 << BLK_LG)))); // R1

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_vld && !pf_rdy && !dmd_vld) |=> (pf_vld && $stable(pf_addr))); // R7

  AST_BURST_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    32'(taken_q) <= LOOKAHEAD + 1); // R8
endmodule

bind stride_prefetcher stride_prefetcher_chk #(
  .ADDR_W(ADDR_W), .BLK_LG(BLK_LG), .PAGE_LG(PAGE_LG), .LOOKAHEAD(LOOKAHEAD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dmd_vld(dmd_vld), .dmd_addr(dmd_addr),
  .pf_vld(pf_vld), .pf_rdy(pf_rdy), .pf_addr(pf_addr)
);

// File: tb/stride_prefetcher_tb.sv
`timescale 1ns/1ps
module stride_prefetcher_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        dmd_vld;
  logic [31:0] dmd_addr;
  logic        pf_vld;
  logic        pf_rdy;
  logic [31:0] pf_addr;

  int checks = 0;
  int errors = 0;

  logic [25:0] m_prev;
  logic [25:0] m_strd;
  logic        m_seen;
  logic [31:0] exp_q [4];
  int          exp_n;
  int          idx;

  always #4 clk = ~clk;

  stride_prefetcher u_dut (
    .clk(clk), .rst_n(rst_n), .dmd_vld(dmd_vld), .dmd_addr(dmd_addr),
    .pf_vld(pf_vld), .pf_rdy(pf_rdy), .pf_addr(pf_addr)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic bit same_pg(input logic [25:0] a, input logic [25:0] b);
    return a[25:6] == b[25:6];
  endfunction

  task automatic model(input logic [31:0] addr);
    logic [25:0] b, d, c;
    b = addr[31:6];
    d = b - m_prev;
    exp_n = 0;
    if (same_pg(b + 26'd1, b)) begin
      exp_q[exp_n] = {b + 26'd1, 6'd0};
      exp_n++;
    end
    if (m_seen && d == m_strd && d != 26'd0) begin
      for (int k = 1; k <= 3; k++) begin
        c = b + d * 26'(k);
        if (same_pg(c, b)) begin
          exp_q[exp_n] = {c, 6'd0};
          exp_n++;
        end
      end
    end
    if (m_seen) m_strd = d;
    m_prev = b;
    m_seen = 1'b1;
    idx = 0;
  endtask

  // called at a falling edge; returns at the next one with the burst loaded
  task automatic demand(input logic [31:0] addr);
    dmd_vld  = 1'b1;
    dmd_addr = addr;
    pf_rdy   = 1'b0;
    model(addr);
    @(negedge clk);
    dmd_vld = 1'b0;
  endtask

  task automatic drain(input int limit, input string tag);
    int taken = 0;
    while (idx < exp_n && taken < limit) begin
      chk(pf_vld === 1'b1 && pf_addr === exp_q[idx], tag, {31'd0, pf_vld} ^ pf_addr, exp_q[idx]);
      pf_rdy = ($urandom % 4) != 0;
      if (pf_rdy) begin
        idx++;
        taken++;
      end
      @(negedge clk);
    end
    pf_rdy = 1'b0;
    if (idx == exp_n) chk(pf_vld === 1'b0, tag, {31'd0, pf_vld}, 32'd0);
  endtask

  task automatic access(input logic [31:0] addr, input string tag);
    demand(addr);
    drain(8, tag);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] base;
    logic [31:0] step;
    void'($urandom(32'd454));
    m_prev = '0; m_strd = '0; m_seen = 1'b0;
    rst_n = 1'b0; dmd_vld = 1'b0; dmd_addr = '0; pf_rdy = 1'b0;
    repeat (3) @(negedge clk);
    chk(pf_vld === 1'b0, "R9 in reset", {31'd0, pf_vld}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pf_vld === 1'b0, "R9 after reset", {31'd0, pf_vld}, 32'd0);

    // R9 / R1: first access only yields the following block
    access(32'h0000_1010, "R9");
    // R1 / R4: unit stride ascending
    access(32'h0000_1040, "R1");
    access(32'h0000_1080, "R3");
    access(32'h0000_10C0, "R4");
    // R3 / R4: stride of 0x200
    access(32'h0000_2000, "R5");
    access(32'h0000_2200, "R5");
    access(32'h0000_2400, "R4");
    chk(exp_n == 4, "R4 burst size", 32'(exp_n), 32'd4);
    access(32'h0000_2600, "R4");
    // R2: stride runs off the page end
    access(32'h0000_3D00, "R5");
    access(32'h0000_3E00, "R5");
    access(32'h0000_3F00, "R2");
    chk(exp_n == 1, "R2 dropped stride", 32'(exp_n), 32'd1);
    // R2: last block of a page offers nothing
    access(32'h0000_7FC4, "R2");
    chk(exp_n == 0, "R2 page end", 32'(exp_n), 32'd0);
    // R6: descending run
    access(32'h0000_5800, "R6");
    access(32'h0000_5700, "R6");
    access(32'h0000_5600, "R6");
    chk(exp_n == 4, "R6 burst size", 32'(exp_n), 32'd4);
    // R10: repeated block
    access(32'h0000_6400, "R10");
    access(32'h0000_6408, "R10");
    access(32'h0000_6420, "R10");
    chk(exp_n == 1, "R10 no stream", 32'(exp_n), 32'd1);
    // R5: break a confirmed run
    access(32'h0000_9000, "R5");
    access(32'h0000_9100, "R5");
    access(32'h0000_9200, "R4");
    access(32'h0000_9240, "R5");
    chk(exp_n == 1, "R5 mismatch", 32'(exp_n), 32'd1);
    // R7: stalled consumer holds the head
    access(32'h0000_A000, "R7");
    access(32'h0000_A080, "R7");
    demand(32'h0000_A100);
    for (int i = 0; i < 3; i++) begin
      chk(pf_vld === 1'b1 && pf_addr === exp_q[0], "R7 hold", pf_addr, exp_q[0]);
      @(negedge clk);
    end
    drain(8, "R7");
    // R8: new access while a burst is half drained
    demand(32'h0000_A180);
    drain(1, "R8");
    access(32'h0000_B000, "R8");
    // random mixed runs, R11 covered by every compared address
    for (int r = 0; r < 60; r++) begin
      base = {$urandom} & 32'hFFFF_FFC0;
      step = ($urandom % 3 == 0) ? 32'($urandom % 16) << 6 : -(32'($urandom % 8) << 6);
      for (int j = 0; j < 2 + int'($urandom % 4); j++) begin
        if ($urandom % 8 == 0) demand(base + 32'($urandom % 64));
        else access(base + step * 32'(j) + 32'($urandom % 64), "R11");
        drain(8, "R8");
      end
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule